// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block merges three reset causes into one reset output stage: the power-on event, a low-supply flag from an external comparator, and an expired watchdog. All timing is counted in millisecond ticks. The ticks arrive as a one-cycle enable, `tick_1ms`, on the system clock. Whichever cause fires, a single stretcher holds reset for a fixed settling period. It restarts that period if another cause shows up while reset is still held.

The watchdog interval comes from a 2-bit select. That select is taken from a register that keeps its value across power cycles, so the block treats it as a static configuration. The software under supervision restarts the watchdog by pulsing a kick strobe. If the kick does not come within the chosen interval, reset is raised. After the stretch period the watchdog starts counting again from zero. Reset is driven in both polarities.

Top module: `sup_reset_wdog`

## Requirements
- R1: While `por_pulse` is high, reset is asserted. After it falls, reset stays asserted for exactly 200 ticks and is released on the clock edge that takes the 200th tick.
- R2: `rst_out` is active-high and `rst_n_out` is active-low. In every cycle they are complements of each other.
- R3: In the cycle after `supply_low` is seen high, reset is asserted. It remains asserted while the flag stays high. Reset is released 200 ticks after the flag is first seen low again.
- R4: The select encoding is 2'b00 = 1400 ticks, 2'b01 = 600 ticks and 2'b10 = 200 ticks. Reset is asserted on the edge that takes the tick completing the interval without a kick.
- R5: With select 2'b11 the watchdog is off, and it never asserts reset however long no kick arrives.
- R6: A kick strobe sampled high clears the watchdog count, so the full interval starts again from that edge.
- R7: A change of the select value clears the watchdog count, so the new interval is measured from the edge that sees the change.
- R8: If a new reset cause appears while reset is held, the 200-tick stretch restarts from zero.
- R9: While reset is held, the watchdog count is held at zero. After a release, counting starts again from zero, so the next timeout comes one full interval after the release.
- R10: The stretch counter advances only on cycles where `tick_1ms` is high. With the tick held low, reset stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous |
| tick_1ms | input | 1 | One-cycle enable, once per millisecond |
| supply_low | input | 1 | Synchronous low-supply flag from the comparator |
| wd_kick | input | 1 | Watchdog restart strobe |
| wd_sel | input | 2 | Watchdog interval select: 00 = 1400, 01 = 600, 10 = 200 ticks, 11 = off |
| rst_out | output | 1 | Reset, active high |
| rst_n_out | output | 1 | Reset, active low |

## Verification
The assertions assume that `supply_low`, `wd_kick` and `wd_sel` are synchronous to `clk`. They also assume that `por_pulse` is the only asynchronous input and that it starts high. The bench changes every input on the falling edge and starts with the power-on pulse active. To make every interval an exact cycle count, the tick runs on every cycle except during one deliberate gap. Select changes are placed only where the bench expects the count to restart, so no interval is cut short by accident.

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog #(
  parameter int STRETCH_TICKS  = 200,
  parameter int WD_SHORT_TICKS = 200,
  parameter int WD_MID_TICKS   = 600,
  parameter int WD_LONG_TICKS  = 1400
) (
  input  logic       clk,
  input  logic       por_pulse,
  input  logic       tick_1ms,
  input  logic       supply_low,
  input  logic       wd_kick,
  input  logic [1:0] wd_sel,
  output logic       rst_out,
  output logic       rst_n_out
);
  localparam int WW = $clog2(WD_LONG_TICKS + 1);
  localparam int SW = $clog2(STRETCH_TICKS + 1);
  localparam logic [1:0] SEL_OFF = 2'b11;

  logic          hold;
  logic [SW-1:0] st_cnt;
  logic [WW-1:0] wd_cnt;
  logic [WW-1:0] wd_limit;
  logic [1:0]    sel_q;
  logic          sel_chg, armed, wd_fire;

  always_comb begin
    case (wd_sel)
      2'b00:   wd_limit = WW'(WD_LONG_TICKS);
      2'b01:   wd_limit = WW'(WD_MID_TICKS);
      2'b10:   wd_limit = WW'(WD_SHORT_TICKS);
      default: wd_limit = '0;
    endcase
  end

  assign sel_chg = wd_sel != sel_q;
  assign armed   = (wd_sel != SEL_OFF) && !hold;
  assign wd_fire = armed && tick_1ms && !wd_kick && !sel_chg &&
                   (wd_cnt == wd_limit - 1'b1);

  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse) begin
      hold   <= 1'b1;
      st_cnt <= '0;
    end else if (supply_low || wd_fire) begin
      hold   <= 1'b1;
      st_cnt <= '0;
    end else if (hold && tick_1ms) begin
      if (st_cnt == SW'(STRETCH_TICKS - 1)) begin
        hold   <= 1'b0;
        st_cnt <= '0;
      end else begin
        st_cnt <= st_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse) begin
      wd_cnt <= '0;
      sel_q  <= SEL_OFF;
    end else begin
      sel_q <= wd_sel;
      if (!armed || wd_kick || sel_chg || wd_fire)
        wd_cnt <= '0;
      else if (tick_1ms)
        wd_cnt <= wd_cnt + 1'b1;
    end
  end

  assign rst_out   = hold;
  assign rst_n_out = ~hold;

  // R3
  sup_hold_chk: assert property (@(posedge clk) disable iff (por_pulse)
    supply_low |=> rst_out);

  // R6
  kick_clr_chk: assert property (@(posedge clk) disable iff (por_pulse)
    wd_kick |=> (wd_cnt == '0));

  // R10
  rel_tick_chk: assert property (@(posedge clk) disable iff (por_pulse)
    $fell(rst_out) |-> $past(tick_1ms));

  // R5
  off_quiet_chk: assert property (@(posedge clk) disable iff (por_pulse)
    (wd_sel == SEL_OFF && !supply_low && !rst_out) |=> !rst_out);

  // R4
  wd_range_chk: assert property (@(posedge clk) disable iff (por_pulse)
    (armed && !sel_chg) |-> (wd_cnt < wd_limit));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (por_pulse)
    (rst_out && supply_low) |=> (rst_out && st_cnt == '0));

  // R9
  held_zero_chk: assert property (@(posedge clk) disable iff (por_pulse)
    rst_out |=> (!rst_out || wd_cnt == '0));
endmodule

// File: tb/sup_reset_wdog_test.sv
module sup_reset_wdog_test;
  logic clk = 1'b0;
  logic por_pulse = 1'b1;
  logic tick_1ms = 1'b1;
  logic supply_low = 1'b0;
  logic wd_kick = 1'b0;
  logic [1:0] wd_sel = 2'b11;
  logic rst_out, rst_n_out;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int    at;
    logic  exp;
    string tag;
  } item_t;
  item_t sb[$];

  sup_reset_wdog uut (
    .clk(clk), .por_pulse(por_pulse), .tick_1ms(tick_1ms),
    .supply_low(supply_low), .wd_kick(wd_kick), .wd_sel(wd_sel),
    .rst_out(rst_out), .rst_n_out(rst_n_out)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int at, input logic v, input string tag);
    item_t it;
    it.at = at; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic go_to(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        checks++;
        if (rst_out !== sb[i].exp || rst_n_out !== ~sb[i].exp) begin
          errors++;
          $display("FAIL %s cycle %0d: rst_out=%b rst_n_out=%b expected %b/%b",
                   sb[i].tag, cyc, rst_out, rst_n_out, sb[i].exp, ~sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    go_to(3);
    checks++;
    if (rst_out !== 1'b1 || rst_n_out !== 1'b0) begin
      errors++;
      $display("FAIL R1 during por: rst_out=%b rst_n_out=%b expected 1/0", rst_out, rst_n_out);
    end
    go_to(5);
    por_pulse = 1'b0;
    // R1 and R2: 200-tick stretch after power-on
    expect_at(6, 1'b1, "R1");
    expect_at(204, 1'b1, "R1");
    expect_at(205, 1'b0, "R2");
    // R5: watchdog off, no kicks
    expect_at(1505, 1'b0, "R5");
    go_to(1600);
    wd_sel = 2'b10;
    // R7 and R4: 200-tick interval measured from the select change
    expect_at(1800, 1'b0, "R7");
    expect_at(1801, 1'b1, "R4");
    expect_at(2000, 1'b1, "R1");
    // R8: supply dip during the hold restarts the stretch
    go_to(2300);
    supply_low = 1'b1;
    go_to(2301);
    supply_low = 1'b0;
    expect_at(2401, 1'b1, "R8");
    expect_at(2500, 1'b1, "R8");
    expect_at(2501, 1'b0, "R8");
    // R9 and R6: 600-tick interval with regular kicks
    go_to(2550);
    wd_sel = 2'b01;
    expect_at(3000, 1'b0, "R6");
    expect_at(3500, 1'b0, "R6");
    expect_at(4000, 1'b0, "R6");
    go_to(2800);
    wd_kick = 1'b1; @(negedge clk); wd_kick = 1'b0;
    go_to(3300);
    wd_kick = 1'b1; @(negedge clk); wd_kick = 1'b0;
    go_to(3800);
    wd_kick = 1'b1; @(negedge clk); wd_kick = 1'b0;
    expect_at(4400, 1'b0, "R4");
    expect_at(4401, 1'b1, "R4");
    expect_at(4600, 1'b1, "R9");
    expect_at(4601, 1'b0, "R9");
    // R4: 1400-tick interval
    go_to(4700);
    wd_sel = 2'b00;
    expect_at(6100, 1'b0, "R4");
    expect_at(6101, 1'b1, "R4");
    expect_at(6300, 1'b1, "R9");
    expect_at(6301, 1'b0, "R9");
    go_to(6400);
    wd_sel = 2'b11;
    // R3: supply low for 50 cycles
    go_to(6600);
    supply_low = 1'b1;
    expect_at(6601, 1'b1, "R3");
    expect_at(6640, 1'b1, "R3");
    expect_at(6849, 1'b1, "R3");
    expect_at(6850, 1'b0, "R3");
    go_to(6650);
    supply_low = 1'b0;
    // R10: tick gap stalls the stretch
    go_to(7000);
    supply_low = 1'b1;
    go_to(7001);
    supply_low = 1'b0;
    go_to(7002);
    tick_1ms = 1'b0;
    expect_at(7250, 1'b1, "R10");
    expect_at(7500, 1'b1, "R10");
    expect_at(7501, 1'b0, "R10");
    go_to(7302);
    tick_1ms = 1'b1;
    go_to(7700);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1 scoreboard: %0d items left, expected 0", sb.size());
    end
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run reached cycle %0d, expected end by 7700", cyc);
    finish_run();
  end
endmodule